// File: doc/BRIEF.md
# Shared-Port Fetch/Data Stall Controller

This block is the control core of a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back) in which instruction fetch and load/store traffic go through one single-ported memory. Fetch wants the port in stage 1 and loads and stores want it in stage 4, so the two can collide in the same cycle. The controller owns the program counter, the decode-stage instruction register and the per-stage control words of the later stages. It decides every cycle who drives the memory port.

Whenever the memory-access stage holds a load or a store, that stage is given the port. The program counter and the decode register are frozen, and a cleared control word (a bubble) is pushed into the execute stage. The bubble then travels to write-back, where it retires nothing. When no data access is pending, the port serves fetch at the current program counter. Two counters record stall cycles and retired instructions, so the cost of the conflict (CPI = 1 + stalls per instruction) can be measured.

An external decoder looks at the decode-stage instruction and returns three control bits. The datapath supplies the address and store data of the memory-stage access.

Top module: `umem_hazard_ctrl`

## Requirements
- R1: While reset is held, decode is invalid, retire and stall are low and both counters read zero. After reset, fetch starts at address 0.
- R2: With no data access pending and fetch_req high, the port reads at the program counter with mem_we low. The fetched word and its address appear on id_instr/id_pc one cycle later, and the program counter advances by one each cycle.
- R3: When the memory stage holds a load or a store, stall is high in that cycle. The port carries ms_addr and ms_wdata, and mem_we equals the store bit.
- R4: During a stall cycle the program counter and the decode register hold. The same fetch address is presented again in the first cycle after the stall.
- R5: Each stall cycle puts a bubble into execute. bubble is high in the following cycle, and two cycles after that write-back holds the bubble, with retire and wb_reg_we low.
- R6: retire is high exactly when write-back holds a valid instruction. retire_count rises by one for each such cycle.
- R7: stall_count rises by one for each stall cycle and is otherwise unchanged.
- R8: A load followed directly by a store gives two consecutive stall cycles and two consecutive bubbles. Decode stays held through both.
- R9: With fetch_req low and no data access pending, mem_en is low, the program counter holds and decode becomes invalid.
- R10: ld_valid is high, with ld_data equal to mem_rdata, only in a stall cycle caused by a load. A store cycle leaves it low.
- R11: A store in the memory stage writes ms_wdata to ms_addr through the port, and the write-back cycle of that store retires with wb_reg_we low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Front end wants to fetch this cycle |
| id_valid | output | 1 | Decode stage holds an instruction |
| id_pc | output | ADDR_W | Address of the decode-stage instruction |
| id_instr | output | DATA_W | Decode-stage instruction word |
| dec_reg_we | input | 1 | Decoded: writes the register file |
| dec_load | input | 1 | Decoded: is a load |
| dec_store | input | 1 | Decoded: is a store |
| ms_addr | input | ADDR_W | Memory-stage data address |
| ms_wdata | input | DATA_W | Memory-stage store data |
| mem_en | output | 1 | Shared port access enable |
| mem_we | output | 1 | Shared port write enable |
| mem_addr | output | ADDR_W | Shared port address |
| mem_wdata | output | DATA_W | Shared port write data |
| mem_rdata | input | DATA_W | Shared port read data, same cycle |
| ld_valid | output | 1 | Load data present on ld_data |
| ld_data | output | DATA_W | Load data to the datapath |
| stall | output | 1 | Data access owns the port; front end held |
| bubble | output | 1 | Execute holds an injected bubble |
| wb_reg_we | output | 1 | Write-back stage writes the register file |
| retire | output | 1 | One instruction completes this cycle |
| stall_count | output | CNT_W | Stall cycles since reset |
| retire_count | output | CNT_W | Retired instructions since reset |

## Verification
The bench runs an all-ALU stream, which should give one retirement per cycle and no stall. It runs a single load and a single store, which show the port switching to the data address and the stall lasting exactly one cycle. A load directly followed by a store separates a one-cycle freeze from the two-cycle one a correct design must give. Holding fetch_req low shows the port left idle instead of fetching. In each run, the cycle where write-back retires nothing is checked, so an early or late bubble is caught.

// File: rtl/umh_pkg.sv
package umh_pkg;

    typedef struct packed {
        logic valid;
        logic reg_we;
        logic load;
        logic store;
    } umh_ctrl_t;

    localparam umh_ctrl_t UMH_NOP = '0;

    localparam int unsigned UMH_EVT_STALL  = 0;
    localparam int unsigned UMH_EVT_RETIRE = 1;
    localparam int unsigned UMH_NUM_EVT    = 2;

endpackage

// File: rtl/umh_port_arb.sv
module umh_port_arb #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              data_req,
    input  logic              data_store,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_grant,
    output logic              port_en,
    output logic              port_we,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] port_wdata
);

    // Fixed priority: the memory-access stage always wins the port.
    always_comb begin
        fetch_grant = 1'b0;
        port_en     = 1'b0;
        port_we     = 1'b0;
        port_addr   = fetch_addr;
        port_wdata  = '0;
        if (data_req) begin
            port_en    = 1'b1;
            port_we    = data_store;
            port_addr  = data_addr;
            port_wdata = data_wdata;
        end else if (fetch_req) begin
            fetch_grant = 1'b1;
            port_en     = 1'b1;
        end
    end

endmodule

// File: rtl/umh_pipe_ctrl.sv
module umh_pipe_ctrl
    import umh_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              fetch_go,
    input  logic [DATA_W-1:0] fetch_word,
    input  umh_ctrl_t         dec_ctrl,
    output logic [ADDR_W-1:0] pc,
    output logic              id_valid,
    output logic [ADDR_W-1:0] id_pc,
    output logic [DATA_W-1:0] id_instr,
    output umh_ctrl_t         mem_ctrl,
    output umh_ctrl_t         wb_ctrl,
    output logic              ex_bubble
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              id_valid;
        logic [ADDR_W-1:0] id_pc;
        logic [DATA_W-1:0] id_instr;
        umh_ctrl_t         ex;
        umh_ctrl_t         mem;
        umh_ctrl_t         wb;
        logic              ex_bubble;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.wb        = st_q.mem;
        st_d.mem       = st_q.ex;
        st_d.ex_bubble = stall;
        if (stall) begin
            // Front end frozen; a cleared word enters execute.
            st_d.ex = UMH_NOP;
        end else begin
            st_d.ex = st_q.id_valid ? dec_ctrl : UMH_NOP;
            if (fetch_go) begin
                st_d.id_valid = 1'b1;
                st_d.id_pc    = st_q.pc;
                st_d.id_instr = fetch_word;
                st_d.pc       = st_q.pc + PC_STEP;
            end else begin
                st_d.id_valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc        = st_q.pc;
    assign id_valid  = st_q.id_valid;
    assign id_pc     = st_q.id_pc;
    assign id_instr  = st_q.id_instr;
    assign mem_ctrl  = st_q.mem;
    assign wb_ctrl   = st_q.wb;
    assign ex_bubble = st_q.ex_bubble;

endmodule

// File: rtl/umh_event_ctr.sv
module umh_event_ctr #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (evt) begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/umem_hazard_ctrl.sv
module umem_hazard_ctrl
    import umh_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    output logic              id_valid,
    output logic [ADDR_W-1:0] id_pc,
    output logic [DATA_W-1:0] id_instr,
    input  logic              dec_reg_we,
    input  logic              dec_load,
    input  logic              dec_store,
    input  logic [ADDR_W-1:0] ms_addr,
    input  logic [DATA_W-1:0] ms_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              stall,
    output logic              bubble,
    output logic              wb_reg_we,
    output logic              retire,
    output logic [CNT_W-1:0]  stall_count,
    output logic [CNT_W-1:0]  retire_count
);

    umh_ctrl_t         dec_ctrl;
    umh_ctrl_t         mem_ctrl;
    umh_ctrl_t         wb_ctrl;
    logic [ADDR_W-1:0] pc;
    logic              fetch_grant;
    logic              data_req;

    logic [UMH_NUM_EVT-1:0]            evt_vec;
    logic [UMH_NUM_EVT-1:0][CNT_W-1:0] evt_cnt;

    always_comb begin
        dec_ctrl.valid  = 1'b1;
        dec_ctrl.reg_we = dec_reg_we;
        dec_ctrl.load   = dec_load;
        dec_ctrl.store  = dec_store;
    end

    assign data_req = mem_ctrl.valid & (mem_ctrl.load | mem_ctrl.store);

    umh_port_arb #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arb (
        .data_req    (data_req),
        .data_store  (mem_ctrl.store),
        .data_addr   (ms_addr),
        .data_wdata  (ms_wdata),
        .fetch_req   (fetch_req),
        .fetch_addr  (pc),
        .fetch_grant (fetch_grant),
        .port_en     (mem_en),
        .port_we     (mem_we),
        .port_addr   (mem_addr),
        .port_wdata  (mem_wdata)
    );

    umh_pipe_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (data_req),
        .fetch_go   (fetch_grant),
        .fetch_word (mem_rdata),
        .dec_ctrl   (dec_ctrl),
        .pc         (pc),
        .id_valid   (id_valid),
        .id_pc      (id_pc),
        .id_instr   (id_instr),
        .mem_ctrl   (mem_ctrl),
        .wb_ctrl    (wb_ctrl),
        .ex_bubble  (bubble)
    );

    assign stall     = data_req;
    assign ld_valid  = data_req & mem_ctrl.load;
    assign ld_data   = mem_rdata;
    assign retire    = wb_ctrl.valid;
    assign wb_reg_we = wb_ctrl.valid & wb_ctrl.reg_we;

    assign evt_vec[UMH_EVT_STALL]  = data_req;
    assign evt_vec[UMH_EVT_RETIRE] = wb_ctrl.valid;

    for (genvar g = 0; g < UMH_NUM_EVT; g++) begin : g_evt
        umh_event_ctr #(
            .CNT_W (CNT_W)
        ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_vec[g]),
            .count (evt_cnt[g])
        );
    end

    assign stall_count  = evt_cnt[UMH_EVT_STALL];
    assign retire_count = evt_cnt[UMH_EVT_RETIRE];

endmodule

// File: rtl/umh_checker.sv
module umh_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] id_pc,
    input logic [DATA_W-1:0] id_instr,
    input logic              mem_en,
    input logic              mem_we,
    input logic              ld_valid,
    input logic              stall,
    input logic              bubble,
    input logic              retire,
    input logic              wb_reg_we,
    input logic [CNT_W-1:0]  stall_count,
    input logic [CNT_W-1:0]  retire_count
);

    // R4
    front_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(id_pc) && $stable(id_instr)));

    // R5
    bubble_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> bubble);

    // R7
    stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (stall_count == $past(stall_count) + CNT_W'(1)));

    // R7
    stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (stall_count == $past(stall_count)));

    // R6
    retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (retire_count == $past(retire_count) + CNT_W'(1)));

    // R9
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_req && !stall) |-> !mem_en);

    // R10
    load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (stall && !mem_we));

    // R6
    retire_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_reg_we |-> retire);

endmodule

bind umem_hazard_ctrl umh_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_req    (fetch_req),
    .id_pc        (id_pc),
    .id_instr     (id_instr),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .ld_valid     (ld_valid),
    .stall        (stall),
    .bubble       (bubble),
    .retire       (retire),
    .wb_reg_we    (wb_reg_we),
    .stall_count  (stall_count),
    .retire_count (retire_count)
);

// File: tb/umem_hazard_ctrl_bench.sv
module umem_hazard_ctrl_bench;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 32;

    // Bench decoder encoding: bit0 reg write, bit1 load, bit2 store.
    localparam logic [31:0] I_ALU   = 32'h1;
    localparam logic [31:0] I_LOAD  = 32'h3;
    localparam logic [31:0] I_STORE = 32'h4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_req = 1'b1;
    logic              id_valid;
    logic [ADDR_W-1:0] id_pc;
    logic [DATA_W-1:0] id_instr;
    logic              dec_reg_we, dec_load, dec_store;
    logic [ADDR_W-1:0] ms_addr = 16'h00A0;
    logic [DATA_W-1:0] ms_wdata = 32'h5555_AAAA;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata, ld_data;
    logic              ld_valid, stall, bubble, wb_reg_we, retire;
    logic [CNT_W-1:0]  stall_count, retire_count;

    logic [31:0] bmem [0:255];
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    assign dec_reg_we = id_instr[0];
    assign dec_load   = id_instr[1];
    assign dec_store  = id_instr[2];
    assign mem_rdata  = bmem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_en && mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    end

    umem_hazard_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_umem_hazard_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_req    (fetch_req),
        .id_valid     (id_valid),
        .id_pc        (id_pc),
        .id_instr     (id_instr),
        .dec_reg_we   (dec_reg_we),
        .dec_load     (dec_load),
        .dec_store    (dec_store),
        .ms_addr      (ms_addr),
        .ms_wdata     (ms_wdata),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .ld_valid     (ld_valid),
        .ld_data      (ld_data),
        .stall        (stall),
        .bubble       (bubble),
        .wb_reg_we    (wb_reg_we),
        .retire       (retire),
        .stall_count  (stall_count),
        .retire_count (retire_count)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Program: bmem[k] = I_ALU except given slots; release reset to cycle N0.
    task automatic start(input logic [31:0] i1, input logic [31:0] i2, input bit freq);
        rst_n = 1'b0;
        fetch_req = freq;
        for (int k = 0; k < 256; k++) bmem[k] = I_ALU;
        bmem[1] = i1;
        bmem[2] = i2;
        bmem[8'hA0] = 32'h0000_ABCD;
        tick();
        tick();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick();
        eq("R1 id_valid in reset", id_valid, 0);
        eq("R1 retire in reset", retire, 0);
        eq("R1 stall in reset", stall, 0);
        eq("R1 stall_count in reset", stall_count, 0);
        eq("R1 retire_count in reset", retire_count, 0);
        start(I_ALU, I_ALU, 1'b1);
        eq("R1 first fetch address", mem_addr, 0);
        eq("R1 first fetch enable", mem_en, 1);
    endtask

    task automatic t_alu_stream();
        start(I_ALU, I_ALU, 1'b1);
        eq("R2 read only", mem_we, 0);
        for (int n = 1; n <= 8; n++) begin
            tick();
            eq("R2 id_pc", id_pc, n - 1);
            eq("R2 id_instr", id_instr, I_ALU);
            eq("R2 fetch addr", mem_addr, n);
            eq("R2 no stall", stall, 0);
            if (n >= 4) eq("R6 retire steady", retire, 1);
        end
        eq("R6 retire_count", retire_count, 4);
        eq("R7 stall_count idle", stall_count, 0);
    endtask

    task automatic t_load();
        start(I_LOAD, I_ALU, 1'b1);
        for (int n = 1; n <= 3; n++) tick();
        tick(); // N4
        eq("R3 stall on load", stall, 1);
        eq("R3 data address", mem_addr, 16'h00A0);
        eq("R3 load no write", mem_we, 0);
        eq("R10 ld_valid", ld_valid, 1);
        eq("R10 ld_data", ld_data, 32'h0000_ABCD);
        eq("R4 id held pc", id_pc, 3);
        tick(); // N5
        eq("R4 id still held", id_pc, 3);
        eq("R4 retry fetch addr", mem_addr, 4);
        eq("R5 bubble flag", bubble, 1);
        eq("R7 stall_count", stall_count, 1);
        eq("R10 ld_valid drop", ld_valid, 0);
        tick(); // N6
        eq("R4 resume", id_pc, 4);
        eq("R6 retire before bubble", retire, 1);
        eq("R5 wb_reg_we before bubble", wb_reg_we, 1);
        tick(); // N7
        eq("R5 bubble retires nothing", retire, 0);
        eq("R5 bubble no reg write", wb_reg_we, 0);
        tick(); // N8
        eq("R6 retire after bubble", retire, 1);
    endtask

    task automatic t_store();
        start(I_STORE, I_ALU, 1'b1);
        for (int n = 1; n <= 4; n++) tick();
        eq("R3 stall on store", stall, 1);
        eq("R3 store write enable", mem_we, 1);
        eq("R3 store address", mem_addr, 16'h00A0);
        eq("R3 store data", mem_wdata, 32'h5555_AAAA);
        eq("R10 no ld_valid on store", ld_valid, 0);
        tick(); // N5
        eq("R11 memory written", bmem[8'hA0], 32'h5555_AAAA);
        eq("R11 store retires", retire, 1);
        eq("R11 store no reg write", wb_reg_we, 0);
    endtask

    task automatic t_back_to_back();
        start(I_LOAD, I_STORE, 1'b1);
        for (int n = 1; n <= 4; n++) tick();
        eq("R8 first stall", stall, 1);
        eq("R8 load read data", ld_data, 32'h0000_ABCD);
        tick(); // N5
        eq("R8 second stall", stall, 1);
        eq("R8 second is store", mem_we, 1);
        eq("R8 id held", id_pc, 3);
        tick(); // N6
        eq("R8 stall ends", stall, 0);
        eq("R8 id held two stalls", id_pc, 3);
        eq("R8 second bubble", bubble, 1);
        eq("R8 stall_count", stall_count, 2);
        eq("R8 store landed", bmem[8'hA0], 32'h5555_AAAA);
        tick(); // N7
        eq("R8 resume", id_pc, 4);
        eq("R8 first bubble at wb", retire, 0);
        tick(); // N8
        eq("R8 second bubble at wb", retire, 0);
        tick(); // N9
        eq("R8 retire resumes", retire, 1);
    endtask

    task automatic t_fetch_idle();
        start(I_ALU, I_ALU, 1'b0);
        eq("R9 port idle", mem_en, 0);
        tick(); // N1
        eq("R9 decode empty", id_valid, 0);
        eq("R9 port still idle", mem_en, 0);
        fetch_req = 1'b1;
        #1;
        eq("R9 pc held at 0", mem_addr, 0);
        eq("R9 fetch resumes", mem_en, 1);
        tick(); // N2
        eq("R9 decode fills", id_valid, 1);
        eq("R9 first id_pc", id_pc, 0);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_alu_stream();
        t_load();
        t_store();
        t_back_to_back();
        t_fetch_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule